// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register file for one DMA channel. A register port reaches four 32-bit words in a 16-byte window. Only byte-address bits [3:2] select a word, so the window decodes correctly at any 16-byte-aligned base.

- **Word 0** holds control and status.
- **Word 1** is the current transfer address.
- **Words 2 and 3** are plain storage.

The control word does several jobs:

- It stores the interrupt state. A pending bit follows edges on the peripheral's interrupt line. A registered interrupt request is raised only while the interrupt-enable bit is set.
- A control write can send a one-cycle reset pulse to the peripheral.
- The channel-enable bit drives a level output that tells the peripheral whether it may move data.
- It keeps a fixed version code and a mask of read-only bits.
- A control write of zero is turned into a drain request.

Each time the peripheral reports a finished transfer, the block adds the transfer's byte count to the address word.

Reads are combinational from the addressed word and have no side effects. A ready flag answers every request one cycle later.

Top module: `dmach_regfile`

## Requirements
- R1: The word index is byte-address bits [3:2]. All other address bits are ignored, so addresses 0x008 and 0xFF8 reach the same word (index 2).
- R2: After synchronous reset:
  - the control word (index 0) reads 0xA0000000;
  - indexes 1 to 3 read zero;
  - irq_out, periph_enable, periph_reset_pulse and rsp_ready are low.
- R3: A control write stores only the bits outside mask 0xFE000007. Masked bits keep their value, and bits 31 and 29 always read one.
- R4: A rising edge on periph_irq sets control bit 0 (pending). irq_out goes high in the next cycle only if control bit 4 (interrupt enable) is set. A falling edge clears bit 0 and drops irq_out.
- R5: A control write with bit 4 set raises irq_out in the next cycle if bit 0 is set. A control write with bit 4 clear drops irq_out.
- R6: A control write with bit 7 set drives periph_reset_pulse high for exactly the next cycle. Bit 7 is stored.
- R7: Drain handling for control bit 6:
  - if written value bit 7 is clear and bit 6 is set, bit 6 is stored as zero;
  - a control write of exactly zero stores bit 6 as one;
  - when bit 7 is set, bit 6 is stored as written.
- R8: periph_enable equals bit 9 of the most recent control write and changes at no other time.
- R9: A write to index 1 stores the value there and sets control bit 26 (loaded). Bit 26 stays set until reset.
- R10: Writes to indexes 2 and 3 store the value unchanged, and only the addressed word changes.
- R11: xfer_done adds xfer_len to the index-1 word, wrapping modulo 2^32. If an index-1 write happens in the same cycle, the written value wins.
- R12: rsp_rdata shows the addressed word combinationally and a read changes no state. rsp_ready is high exactly one cycle after a cycle with req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Registered acknowledge, one cycle after request |
| rsp_rdata | output | 32 | Combinational read data of the addressed word |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| irq_out | output | 1 | Registered interrupt request |
| periph_reset_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| periph_enable | output | 1 | Channel-enable level to the peripheral |
| xfer_done | input | 1 | Strobe: one transfer finished |
| xfer_len | input | LEN_W | Byte count of the finished transfer |

## Verification
The control word is written with several distinct patterns, each aimed at a different rule:
- all ones, which tells the read-only mask and the reset pulse apart from the drain rule;
- drain together with interrupt enable, which shows the drain bit being dropped;
- exactly zero, which shows drain being forced on;
- enable-only and enable-plus-interrupt values, which separate the interrupt gating from the peripheral enable level.

The interrupt input is toggled with interrupt enable both clear and set, so a design that ignores the gate or holds a stale pending bit is exposed. The address word is advanced by several byte counts, across the 2^32 wrap, and in the same cycle as a direct write, which exposes a missing carry or a wrong priority. Aliased addresses and repeated reads separate a correct index decode from a full-address decode and show that reads have no side effects.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int DW    = 32;
    localparam int NREG  = 4;
    localparam int IDX_W = $clog2(NREG);
    localparam int GP_FIRST = 2;
    localparam int GP_COUNT = NREG - GP_FIRST;

    localparam logic [DW-1:0] CTRL_RO_MASK = 32'hFE00_0007;
    localparam logic [DW-1:0] CTRL_VERSION = 32'hA000_0000;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_RST    = 7;
    localparam int B_DIR    = 8;
    localparam int B_EN     = 9;
    localparam int B_LOADED = 26;

    typedef enum logic [IDX_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_GP2  = 2'd2,
        SEL_GP3  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } reg_wr_t;

    function automatic reg_sel_e decode_index(input logic [3:0] low_addr);
        return reg_sel_e'(low_addr[3:2]);
    endfunction

    // Apply the reset / drain / zero rules to an incoming control value.
    function automatic logic [DW-1:0] shape_ctrl(input logic [DW-1:0] val);
        logic [DW-1:0] v;
        v = val;
        if (!v[B_RST]) begin
            if (v[B_DRAIN])
                v[B_DRAIN] = 1'b0;
            else if (v == '0)
                v[B_DRAIN] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [DW-1:0] merge_ctrl(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w);
        return (old_w & CTRL_RO_MASK) | (new_w & ~CTRL_RO_MASK) | CTRL_VERSION;
    endfunction
endpackage

// File: rtl/dmach_ctrl_word.sv
module dmach_ctrl_word
    import dmach_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          set_loaded,
    input  logic          irq_level,
    output logic [DW-1:0] ctrl_q,
    output logic          irq_q,
    output logic          rst_pulse_q,
    output logic          en_q
);
    logic          irq_in_q;
    logic          rise, fall;
    logic          pend_next;
    logic          irq_next;
    logic [DW-1:0] ctrl_next;

    assign rise = irq_level & ~irq_in_q;
    assign fall = ~irq_level & irq_in_q;

    always_comb begin
        pend_next = ctrl_q[B_PEND];
        if (rise)
            pend_next = 1'b1;
        else if (fall)
            pend_next = 1'b0;

        ctrl_next = ctrl_q;
        if (wr_en)
            ctrl_next = merge_ctrl(ctrl_q, shape_ctrl(wr_data));
        ctrl_next[B_PEND] = pend_next;
        if (set_loaded)
            ctrl_next[B_LOADED] = 1'b1;

        irq_next = irq_q;
        if (wr_en)
            irq_next = wr_data[B_IEN] & pend_next;
        else if (rise)
            irq_next = ctrl_q[B_IEN];
        else if (fall)
            irq_next = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= CTRL_VERSION;
            irq_q       <= 1'b0;
            rst_pulse_q <= 1'b0;
            en_q        <= 1'b0;
            irq_in_q    <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_next;
            irq_q       <= irq_next;
            rst_pulse_q <= wr_en & wr_data[B_RST];
            if (wr_en)
                en_q <= wr_data[B_EN];
            irq_in_q    <= irq_level;
        end
    end
endmodule

// File: rtl/dmach_addr_ptr.sv
module dmach_addr_ptr
    import dmach_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             adv,
    input  logic [LEN_W-1:0] adv_len,
    output logic [DW-1:0]    addr_q
);
    logic [DW-1:0] len_ext;
    assign len_ext = DW'(adv_len);

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (wr_en)
            addr_q <= wr_data;
        else if (adv)
            addr_q <= addr_q + len_ext;
    end
endmodule

// File: rtl/dmach_gp_bank.sv
module dmach_gp_bank
    import dmach_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DW-1:0]                wr_data,
    output logic [GP_COUNT-1:0][DW-1:0]  regs_q
);
    for (genvar g = 0; g < GP_COUNT; g++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + GP_FIRST);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (wr_en && wr_idx == MY_IDX)
                regs_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    input  logic              periph_irq,
    output logic              irq_out,
    output logic              periph_reset_pulse,
    output logic              periph_enable,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len
);
    reg_wr_t                        wreq;
    logic [DW-1:0]                  ctrl_word;
    logic [DW-1:0]                  addr_word;
    logic [GP_COUNT-1:0][DW-1:0]    gp_words;
    logic                           addr_unused;

    assign addr_unused = ^{req_addr[ADDR_W-1:4], req_addr[1:0]};

    assign wreq.wr   = req_valid & req_write;
    assign wreq.sel  = decode_index(req_addr[3:0]);
    assign wreq.data = req_wdata;

    dmach_ctrl_word u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wreq.wr && wreq.sel == SEL_CTRL),
        .wr_data     (wreq.data),
        .set_loaded  (wreq.wr && wreq.sel == SEL_ADDR),
        .irq_level   (periph_irq),
        .ctrl_q      (ctrl_word),
        .irq_q       (irq_out),
        .rst_pulse_q (periph_reset_pulse),
        .en_q        (periph_enable)
    );

    dmach_addr_ptr #(.LEN_W(LEN_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wreq.wr && wreq.sel == SEL_ADDR),
        .wr_data (wreq.data),
        .adv     (xfer_done),
        .adv_len (xfer_len),
        .addr_q  (addr_word)
    );

    dmach_gp_bank u_gp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wreq.wr),
        .wr_idx  (wreq.sel),
        .wr_data (wreq.data),
        .regs_q  (gp_words)
    );

    always_comb begin
        unique case (wreq.sel)
            SEL_CTRL: rsp_rdata = ctrl_word;
            SEL_ADDR: rsp_rdata = addr_word;
            SEL_GP2:  rsp_rdata = gp_words[0];
            default:  rsp_rdata = gp_words[1];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_ready <= 1'b0;
        else
            rsp_ready <= req_valid;
    end
endmodule

// File: rtl/dmach_regfile_chk.sv
module dmach_regfile_chk
    import dmach_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_idx,
    input logic [31:0]      req_wdata,
    input logic             xfer_done,
    input logic [LEN_W-1:0] xfer_len,
    input logic             rsp_ready,
    input logic             irq_out,
    input logic             periph_reset_pulse,
    input logic             periph_enable,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      addr_q
);
    logic ctrl_wr, addr_wr;
    assign ctrl_wr = req_valid && req_write && req_idx == 2'd0;
    assign addr_wr = req_valid && req_write && req_idx == 2'd1;

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        periph_reset_pulse |-> $past(ctrl_wr && req_wdata[B_RST])); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (periph_reset_pulse && !(ctrl_wr && req_wdata[B_RST])) |=> !periph_reset_pulse); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (ctrl_q[B_IEN] && ctrl_q[B_PEND])); // R4
    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[B_LOADED] |=> ctrl_q[B_LOADED]); // R9
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !addr_wr) |=> addr_q == $past(addr_q) + 32'($past(xfer_len))); // R11
    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready); // R12
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ready); // R12
    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(periph_enable)); // R8
endmodule

bind dmach_regfile dmach_regfile_chk #(.LEN_W(LEN_W)) u_chk (
    .clk                (clk),
    .rst                (rst),
    .req_valid          (req_valid),
    .req_write          (req_write),
    .req_idx            (req_addr[3:2]),
    .req_wdata          (req_wdata),
    .xfer_done          (xfer_done),
    .xfer_len           (xfer_len),
    .rsp_ready          (rsp_ready),
    .irq_out            (irq_out),
    .periph_reset_pulse (periph_reset_pulse),
    .periph_enable      (periph_enable),
    .ctrl_q             (ctrl_word),
    .addr_q             (addr_word)
);

// File: tb/tb_dmach_regfile.sv
`timescale 1ns/1ps
module tb_dmach_regfile;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_ready;
    logic [31:0]       rsp_rdata;
    logic              periph_irq = 1'b0;
    logic              irq_out;
    logic              periph_reset_pulse;
    logic              periph_enable;
    logic              xfer_done = 1'b0;
    logic [LEN_W-1:0]  xfer_len = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dmach_regfile #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .periph_irq(periph_irq), .irq_out(irq_out),
        .periph_reset_pulse(periph_reset_pulse), .periph_enable(periph_enable),
        .xfer_done(xfer_done), .xfer_len(xfer_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [4];
    logic        m_irq, m_en, m_pulse, m_ready, m_in_q, m_live;
    logic [31:0] t_val;
    logic        t_pend, t_wr;
    int          t_idx;

    initial m_live = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_reg[0] = 32'hA000_0000;
            m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
            m_irq = 0; m_en = 0; m_pulse = 0; m_ready = 0; m_in_q = 0;
            m_live = 1'b1;
        end else if (m_live) begin
            t_wr  = req_valid && req_write;
            t_idx = int'(req_addr[3:2]);
            t_pend = m_reg[0][0];
            if (periph_irq && !m_in_q) t_pend = 1;
            else if (!periph_irq && m_in_q) t_pend = 0;
            m_pulse = t_wr && t_idx == 0 && req_wdata[7];
            if (t_wr && t_idx == 0) begin
                m_irq = req_wdata[4] && t_pend;
                m_en  = req_wdata[9];
                t_val = req_wdata;
                if (!t_val[7] && t_val[6]) t_val[6] = 0;
                else if (!t_val[7] && t_val == 0) t_val = 32'h40;
                m_reg[0] = (m_reg[0] & 32'hFE00_0007) | (t_val & 32'h01FF_FFF8) | 32'hA000_0000;
            end else if (periph_irq && !m_in_q) begin
                m_irq = m_reg[0][4];
            end else if (!periph_irq && m_in_q) begin
                m_irq = 0;
            end
            m_reg[0][0] = t_pend;
            if (t_wr && t_idx == 1) begin
                m_reg[1] = req_wdata;
                m_reg[0][26] = 1;
            end else if (xfer_done) begin
                m_reg[1] = m_reg[1] + 32'(xfer_len);
            end
            if (t_wr && t_idx >= 2) m_reg[t_idx] = req_wdata;
            m_ready = req_valid;
            m_in_q  = periph_irq;
        end
    end

    always @(negedge clk) begin
        if (m_live && !rst) begin
            check("R4/R5 irq_out", 32'(irq_out), 32'(m_irq));
            check("R8 periph_enable", 32'(periph_enable), 32'(m_en));
            check("R6 periph_reset_pulse", 32'(periph_reset_pulse), 32'(m_pulse));
            check("R12 rsp_ready", 32'(rsp_ready), 32'(m_ready));
            if (req_valid && !req_write)
                check("R12 rsp_rdata model", rsp_rdata, m_reg[req_addr[3:2]]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        @(negedge clk); #1;
        req_valid = 0; req_write = 0; xfer_done = 0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; xfer_done = 0;
        idle();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1;
        req_valid = 1; req_write = 0; req_addr = a; xfer_done = 0;
        @(negedge clk);
        check(req, rsp_rdata, exp);
        check("R12 ready after read", 32'(rsp_ready), 32'd1);
        #1 req_valid = 0;
    endtask

    task automatic done(input logic [LEN_W-1:0] n);
        @(negedge clk); #1;
        req_valid = 0; xfer_done = 1; xfer_len = n;
        idle();
    endtask

    task automatic set_irq(input logic lvl);
        @(negedge clk); #1;
        periph_irq = lvl;
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;
        @(negedge clk);
        check("R2 irq_out reset", 32'(irq_out), 0);
        check("R2 enable reset", 32'(periph_enable), 0);
        check("R2 ready reset", 32'(rsp_ready), 0);
        rd(12'h000, 32'hA000_0000, "R2 ctrl reset");
        rd(12'h004, 32'h0, "R2 addr reset");
        rd(12'h00C, 32'h0, "R2 gp3 reset");

        // R1 / R10: plain words and aliasing
        wr(12'h008, 32'h1234_5678);
        wr(12'hFFC, 32'hCAFE_0001);
        rd(12'hFF8, 32'h1234_5678, "R1 alias gp2");
        rd(12'h10C, 32'hCAFE_0001, "R10 gp3");
        rd(12'h001, 32'hA000_0000, "R10 ctrl untouched");

        // R3 / R6: all ones; reset pulse on next cycle only
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 12'h000; req_wdata = 32'hFFFF_FFFF;
        @(negedge clk); #1 req_valid = 0;
        check("R6 pulse high", 32'(periph_reset_pulse), 1);
        check("R8 enable set", 32'(periph_enable), 1);
        @(negedge clk);
        check("R6 pulse single", 32'(periph_reset_pulse), 0);
        rd(12'h000, 32'hA1FF_FFF8, "R3 ro mask");

        // R7 drain cleared, R8 enable dropped
        wr(12'h000, 32'h0000_0050);
        rd(12'h000, 32'hA000_0010, "R7 drain cleared");
        check("R8 enable low", 32'(periph_enable), 0);
        wr(12'h000, 32'h0);
        rd(12'h000, 32'hA000_0040, "R7 zero becomes drain");

        // R4 / R5 interrupt handling
        set_irq(1);
        check("R4 gated irq", 32'(irq_out), 0);
        rd(12'h000, 32'hA000_0041, "R4 pending set");
        wr(12'h000, 32'h0000_0010);
        check("R5 irq raised by enable", 32'(irq_out), 1);
        wr(12'h000, 32'h0000_0200);
        check("R5 irq lowered", 32'(irq_out), 0);
        check("R8 enable level", 32'(periph_enable), 1);
        rd(12'h000, 32'hA000_0201, "R3 pending kept");
        wr(12'h000, 32'h0000_0210);
        check("R5 irq raised again", 32'(irq_out), 1);
        set_irq(0);
        check("R4 irq fall", 32'(irq_out), 0);
        rd(12'h000, 32'hA000_0210, "R4 pending cleared");
        set_irq(1);
        check("R4 irq rise enabled", 32'(irq_out), 1);
        set_irq(0);

        // R9 loaded, R11 advance
        wr(12'h004, 32'h0000_1000);
        rd(12'h000, 32'hA400_0210, "R9 loaded bit");
        rd(12'h004, 32'h0000_1000, "R9 addr stored");
        done(16'h20);
        done(16'h3);
        done(16'h3);
        rd(12'h004, 32'h0000_1026, "R11 advance");
        wr(12'h004, 32'hFFFF_FFF0);
        done(16'h20);
        rd(12'h004, 32'h0000_0010, "R11 wrap");
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 12'h004; req_wdata = 32'h0000_5000;
        xfer_done = 1; xfer_len = 16'h8;
        idle();
        rd(12'h004, 32'h0000_5000, "R11 write wins");

        // R12 reads have no side effects
        rd(12'h000, 32'hA400_0210, "R12 repeat read 1");
        rd(12'h000, 32'hA400_0210, "R12 repeat read 2");
        check("R12 irq unchanged", 32'(irq_out), 0);

        repeat (3) idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule